// File: doc/BRIEF.md
# Lane Power-Gating Controller

This block manages the power state of one lane of a router output: the channel wires and the matching crossbar slice are powered on and off together, and the downstream virtual-channel buffer that the lane feeds is moved between a low-leakage drowsy mode and a fully awake mode. A wake request comes from the upstream router when a flit wins switch allocation for this lane. The request arrives one pipeline stage ahead of the flit, so the wake latency is hidden behind the flit's remaining pipeline stages. The lane is never powered on speculatively: only a real allocation win starts a wake.

The lane and the buffer run on separate timers. After a request, the lane spends a fixed number of cycles waking before it reports ready. It then holds a minimum on-time and turns off only after a run of fully quiet cycles. The buffer wakes in one cycle, keeps its contents while drowsy, and goes back to drowsy after a short run of empty, request-free cycles. It is never put to sleep while it still holds flits.

Top module: `lane_pwr_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, `lane_en_o`, `lane_ready_o` and `buf_wake_o` are all 0. Reset leaves the lane off with its buffer drowsy.
- R2: When `sa_win_i` is sampled high at a clock edge while the lane is off, `lane_en_o` is 1 right after that edge. `lane_ready_o` becomes 1 right after the WAKE_CYC-th edge counted from that edge (edge 3 with defaults).
- R3: `lane_ready_o` is never 1 while `lane_en_o` is 0.
- R4: A request sampled while the lane is waking, on any edge up to and including the edge that completes the wake, has no effect on when `lane_ready_o` rises. Once a wake has started, `lane_en_o` stays 1.
- R5: After `lane_ready_o` rises, the lane stays enabled for at least MIN_ON edges (15 with defaults), even if every one of those cycles is quiet.
- R6: The lane turns off (both `lane_en_o` and `lane_ready_o` go to 0) at the first edge at which at least MIN_ON edges have passed since ready rose and the last IDLE_OFF sampled cycles (6 with defaults) each had `sa_win_i`=0 and `lane_flit_i`=0.
- R7: A request sampled while the lane is ready restarts the quiet-cycle count, and `lane_ready_o` stays 1 without any new wake delay.
- R8: A request sampled at any edge makes `buf_wake_o` and `lane_en_o` 1 right after that edge.
- R9: An awake buffer returns to drowsy (`buf_wake_o`=0) right after the BUF_IDLE-th consecutive edge (3 with defaults) at which both `sa_win_i` and `buf_nonempty_i` were 0. The count starts from the edge that woke the buffer or from the last edge at which either input was high.
- R10: `buf_wake_o` never falls right after an edge at which `buf_nonempty_i` was sampled 1.
- R11: `lane_en_o` and `buf_wake_o` rise only right after an edge at which `sa_win_i` was 1. Traffic and occupancy inputs alone never wake anything.
- R12: `lane_ready_o` falls only at the same edge as `lane_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sa_win_i | input | 1 | Upstream switch-allocation win targeting this lane (wake request) |
| lane_flit_i | input | 1 | A flit is using the lane this cycle |
| buf_nonempty_i | input | 1 | The mapped downstream VC buffer holds at least one flit |
| lane_en_o | output | 1 | Power enable for the channel and crossbar lane (1 = powered) |
| lane_ready_o | output | 1 | Lane is fully woken and usable |
| buf_wake_o | output | 1 | Buffer mode (1 = awake, 0 = drowsy) |

## Verification
The main function is driven with a set of request, traffic and occupancy patterns, starting each time from the off state. These are: a single request with no traffic; traffic that ends before or after the minimum on-time; a second request placed during the wake, on the wake's final edge, or during the idle countdown; and buffer occupancy that holds off the buffer timer. Because outputs are compared on every cycle, the patterns separate a wrong wake length, a min-on timer that is ignored or dominant, an idle counter that is not restarted, and a buffer timer that ignores occupancy or requests. Directed cases add a request held high for many cycles, traffic and occupancy with no request, and a reset taken while the lane is on.

// File: rtl/lanepg_pkg.sv
package lanepg_pkg;

    typedef enum logic [1:0] {
        LS_OFF   = 2'd0,
        LS_WAKE  = 2'd1,
        LS_ON    = 2'd2,
        LS_DRAIN = 2'd3
    } lane_st_e;

    typedef struct packed {
        logic req;   // allocation win for this lane
        logic busy;  // flit on the lane this cycle
    } lane_evt_t;

    // counter width able to hold 0..n
    function automatic int cw(int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    function automatic logic lane_quiet(lane_evt_t e);
        return !e.req && !e.busy;
    endfunction

endpackage

// File: rtl/lane_chan_fsm.sv
module lane_chan_fsm
    import lanepg_pkg::*;
#(
    parameter int WAKE_CYC = 3,
    parameter int MIN_ON   = 15,
    parameter int IDLE_OFF = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  lane_evt_t evt,
    output logic      lane_en,
    output logic      lane_ready
);
    localparam int WW = cw(WAKE_CYC);
    localparam int AW = cw(MIN_ON);
    localparam int IW = cw(IDLE_OFF);
    localparam logic [WW-1:0] W_LOAD   = WW'(WAKE_CYC - 1);
    localparam logic [AW-1:0] AGE_SAT  = AW'(MIN_ON);
    localparam logic [IW-1:0] IDLE_SAT = IW'(IDLE_OFF);

    lane_st_e        st_q, st_d;
    logic [WW-1:0]   w_q, w_d;
    logic [AW-1:0]   age_q, age_d, age_inc;
    logic [IW-1:0]   idle_q, idle_d, idle_inc;
    logic            quiet;
    logic            min_done;

    always_comb begin
        quiet    = lane_quiet(evt);
        age_inc  = (age_q == AGE_SAT) ? age_q : age_q + 1'b1;
        idle_inc = !quiet ? '0 : ((idle_q == IDLE_SAT) ? idle_q : idle_q + 1'b1);
        min_done = (age_inc == AGE_SAT);
        st_d     = st_q;
        w_d      = w_q;
        age_d    = age_q;
        idle_d   = idle_q;
        unique case (st_q)
            LS_OFF: begin
                if (evt.req) begin
                    st_d = LS_WAKE;
                    w_d  = W_LOAD;
                end
            end
            LS_WAKE: begin
                // requests here are absorbed; the wake runs to completion
                if (w_q == '0) begin
                    st_d   = LS_ON;
                    age_d  = '0;
                    idle_d = '0;
                end else begin
                    w_d = w_q - 1'b1;
                end
            end
            LS_ON, LS_DRAIN: begin
                age_d  = age_inc;
                idle_d = idle_inc;
                if (min_done && idle_inc == IDLE_SAT) begin
                    st_d   = LS_OFF;
                    age_d  = '0;
                    idle_d = '0;
                end else if (min_done && idle_inc != '0) begin
                    st_d = LS_DRAIN;
                end else begin
                    st_d = LS_ON;
                end
            end
            default: st_d = LS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LS_OFF;
            w_q    <= '0;
            age_q  <= '0;
            idle_q <= '0;
        end else begin
            st_q   <= st_d;
            w_q    <= w_d;
            age_q  <= age_d;
            idle_q <= idle_d;
        end
    end

    assign lane_en    = (st_q != LS_OFF);
    assign lane_ready = (st_q == LS_ON) || (st_q == LS_DRAIN);

endmodule

// File: rtl/lane_buf_ctrl.sv
module lane_buf_ctrl
    import lanepg_pkg::*;
#(
    parameter int BUF_IDLE = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic nonempty,
    output logic buf_wake
);
    localparam int BW = cw(BUF_IDLE);
    localparam logic [BW-1:0] B_LIMIT = BW'(BUF_IDLE);

    logic          wake_q, wake_d;
    logic [BW-1:0] cnt_q, cnt_d, cnt_inc;

    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        wake_d  = wake_q;
        cnt_d   = cnt_q;
        if (req) begin
            wake_d = 1'b1;
            cnt_d  = '0;
        end else if (nonempty) begin
            // occupied buffer: hold the timer, never doze
            cnt_d = '0;
        end else if (wake_q) begin
            if (cnt_inc >= B_LIMIT) begin
                wake_d = 1'b0;
                cnt_d  = '0;
            end else begin
                cnt_d = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            wake_q <= wake_d;
            cnt_q  <= cnt_d;
        end
    end

    assign buf_wake = wake_q;

endmodule

// File: rtl/lane_pwr_ctrl.sv
module lane_pwr_ctrl
    import lanepg_pkg::*;
#(
    parameter int WAKE_CYC = 3,
    parameter int MIN_ON   = 15,
    parameter int IDLE_OFF = 6,
    parameter int BUF_IDLE = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic sa_win_i,
    input  logic lane_flit_i,
    input  logic buf_nonempty_i,
    output logic lane_en_o,
    output logic lane_ready_o,
    output logic buf_wake_o
);
    lane_evt_t evt;

    always_comb begin
        evt.req  = sa_win_i;
        evt.busy = lane_flit_i;
    end

    lane_chan_fsm #(
        .WAKE_CYC(WAKE_CYC),
        .MIN_ON  (MIN_ON),
        .IDLE_OFF(IDLE_OFF)
    ) u_chan (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .lane_en   (lane_en_o),
        .lane_ready(lane_ready_o)
    );

    lane_buf_ctrl #(
        .BUF_IDLE(BUF_IDLE)
    ) u_buf (
        .clk     (clk),
        .rst     (rst),
        .req     (sa_win_i),
        .nonempty(buf_nonempty_i),
        .buf_wake(buf_wake_o)
    );

endmodule

// File: rtl/lane_pwr_ctrl_chk.sv
module lane_pwr_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic sa_win_i,
    input logic buf_nonempty_i,
    input logic lane_en_o,
    input logic lane_ready_o,
    input logic buf_wake_o
);
    p_ready_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        lane_ready_o |-> lane_en_o);

    p_wake_sticks_r4: assert property (@(posedge clk) disable iff (rst)
        (lane_en_o && !lane_ready_o) |=> lane_en_o);

    p_req_keeps_ready_r7: assert property (@(posedge clk) disable iff (rst)
        (lane_ready_o && sa_win_i) |=> lane_ready_o);

    p_req_wakes_r8: assert property (@(posedge clk) disable iff (rst)
        sa_win_i |=> (buf_wake_o && lane_en_o));

    p_full_buf_awake_r10: assert property (@(posedge clk) disable iff (rst)
        (buf_wake_o && buf_nonempty_i) |=> buf_wake_o);

    p_lane_rise_cause_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(lane_en_o) |-> $past(sa_win_i));

    p_buf_rise_cause_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_wake_o) |-> $past(sa_win_i));

    p_ready_fall_with_en_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(lane_ready_o) |-> $fell(lane_en_o));

endmodule

bind lane_pwr_ctrl lane_pwr_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .sa_win_i      (sa_win_i),
    .buf_nonempty_i(buf_nonempty_i),
    .lane_en_o     (lane_en_o),
    .lane_ready_o  (lane_ready_o),
    .buf_wake_o    (buf_wake_o)
);

// File: tb/tb_lane_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_lane_pwr_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sa_win_i = 1'b0;
    logic lane_flit_i = 1'b0;
    logic buf_nonempty_i = 1'b0;
    logic lane_en_o, lane_ready_o, buf_wake_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    lane_pwr_ctrl dut (
        .clk           (clk),
        .rst           (rst),
        .sa_win_i      (sa_win_i),
        .lane_flit_i   (lane_flit_i),
        .buf_nonempty_i(buf_nonempty_i),
        .lane_en_o     (lane_en_o),
        .lane_ready_o  (lane_ready_o),
        .buf_wake_o    (buf_wake_o)
    );

    // columns: second request edge (0 = none), busy cycles after ready,
    // occupied cycles after wake, lane off edge, first buffer doze edge,
    // second buffer wake edge (0 = none), second buffer doze edge
    localparam int NV = 9;
    localparam int VT [NV][7] = '{
        '{ 0,  0, 0, 18,  3,  0,  0},
        '{ 0, 12, 0, 21,  3,  0,  0},
        '{ 0,  5, 0, 18,  3,  0,  0},
        '{ 2,  0, 0, 18,  5,  0,  0},
        '{15,  0, 0, 21,  3, 15, 18},
        '{17,  0, 0, 23,  3, 17, 20},
        '{ 0,  0, 4, 18,  7,  0,  0},
        '{16, 10, 9, 22, 12, 16, 19},
        '{ 3,  0, 0, 18,  6,  0,  0}
    };

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        // R1: reset state
        repeat (4) @(posedge clk);
        #1;
        chk(lane_en_o, 1'b0, "R1 lane_en in reset");
        chk(lane_ready_o, 1'b0, "R1 ready in reset");
        chk(buf_wake_o, 1'b0, "R1 buffer drowsy in reset");
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        chk(lane_en_o, 1'b0, "R1 lane_en after reset");
        chk(buf_wake_o, 1'b0, "R1 buffer after reset");

        // table walk: edge c is the c-th edge after the first request
        for (int v = 0; v < NV; v++) begin
            for (int c = 0; c < 32; c++) begin
                @(negedge clk);
                sa_win_i       = (c == 0) || (VT[v][0] != 0 && c == VT[v][0]);
                lane_flit_i    = (c >= 4) && (c <= 3 + VT[v][1]);
                buf_nonempty_i = (c >= 1) && (c <= VT[v][2]);
                @(posedge clk); #1;
                // R2 R4 R5 R6 R7 lane timing, R3 R12 by joint compare
                chk(lane_en_o, c < VT[v][3],
                    $sformatf("R2 R5 R6 R7 lane_en vec%0d edge%0d", v, c));
                chk(lane_ready_o, (c >= 3) && (c < VT[v][3]),
                    $sformatf("R2 R4 R6 R7 ready vec%0d edge%0d", v, c));
                chk(buf_wake_o, (c < VT[v][4]) ||
                    (VT[v][5] != 0 && c >= VT[v][5] && c < VT[v][6]),
                    $sformatf("R8 R9 R10 buffer vec%0d edge%0d", v, c));
            end
        end

        // R11: traffic and occupancy without a request wake nothing
        @(negedge clk);
        sa_win_i = 1'b0; lane_flit_i = 1'b1; buf_nonempty_i = 1'b1;
        for (int c = 0; c < 10; c++) begin
            @(posedge clk); #1;
            chk(lane_en_o, 1'b0, "R11 lane stays off");
            chk(buf_wake_o, 1'b0, "R11 buffer stays drowsy");
        end
        @(negedge clk);
        lane_flit_i = 1'b0; buf_nonempty_i = 1'b0;
        repeat (3) @(posedge clk);

        // request held for 40 edges: R4 ready timing, R6 off, R9 doze
        for (int c = 0; c < 50; c++) begin
            @(negedge clk);
            sa_win_i = (c < 40);
            @(posedge clk); #1;
            if (c == 2)  chk(lane_ready_o, 1'b0, "R4 held request still waking");
            if (c == 3)  chk(lane_ready_o, 1'b1, "R4 held request ready on time");
            if (c == 39) chk(lane_ready_o, 1'b1, "R7 held request keeps ready");
            if (c == 41) chk(buf_wake_o, 1'b1, "R9 buffer before doze");
            if (c == 42) chk(buf_wake_o, 1'b0, "R9 buffer dozes");
            if (c == 44) chk(lane_en_o, 1'b1, "R6 lane before idle run ends");
            if (c == 45) chk(lane_en_o, 1'b0, "R6 lane off after idle run");
        end

        // R1: reset taken while lane is on
        @(negedge clk) sa_win_i = 1'b1;
        @(negedge clk) sa_win_i = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1;
        chk(lane_en_o, 1'b0, "R1 reset turns lane off");
        chk(lane_ready_o, 1'b0, "R1 reset clears ready");
        chk(buf_wake_o, 1'b0, "R1 reset makes buffer drowsy");
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        chk(lane_en_o, 1'b0, "R1 lane off after mid-run reset");

        report();
    end
endmodule